// File: doc/BRIEF.md
# Scan Job Dispatch and Repeat Controller

This block launches a scan job when a processor writes the start registers, and it decides how the job loops. The processor write arrives as a single-cycle `newData` pulse that carries the job settings: sequence or single-vector mode, the compare enable, the two repeat counts and a header base address. On the edge where the pulse is sampled, the block stores these settings. During the following cycle it decodes the mode. It then loads the pointer register on back-to-back cycles to fetch the structure headers, and finally loads the test-data address, at which point it strobes the serializer.

While a vector is being shifted, the block waits for the serializer and comparator to report the end of the vector (`vecDone`, with `cmpFail` valid in the same cycle). A failing compare, when compare is enabled, restarts the whole sequence and uses up one sequence repeat. A pass, or any result when compare is disabled, re-runs the vector and uses up one vector repeat. Each loop leaves when its count is zero, and the block then returns to idle. The serializer, comparator and memory sit outside this block.

Top module: `scan_dispatch`

## Requirements
- R1: Out of reset, `busy`, `ptrLoad` and `shiftStart` are low. A `newData` pulse sampled while idle stores all `wr*` inputs on that edge. `busy` is high from the next cycle on, and `ptrLoad` stays low in that cycle, which is the decode cycle.
- R2: The mode is decoded in the cycle after the store. Exactly two cycles after the `newData` edge, the first pointer load appears: address base+0 (sequence header) when `wrSeqMode`=1, and base+1 (vector header) when `wrSeqMode`=0.
- R3: Pointer loads occur on consecutive cycles, with `ptrLoad` high in each. Sequence mode gives base+0, base+1, base+2, base+3. Single-vector mode gives base+1, base+2, base+3. Offset 2 is the macro header and offset 3 is the test-data area. Addresses wrap modulo 2^ADDR_W.
- R4: `shiftStart` is high for exactly one cycle, in the same cycle as the base+3 data-area load, and at no other time.
- R5: When a `vecDone` is sampled with `wrCmpEn`=1, `cmpFail`=1 and a sequence repeat count that is not zero, the count drops by one and the vector count is restored to its stored value. One gap cycle later the loads restart from base+0 in sequence mode, or from base+1 in single-vector mode.
- R6: When a `vecDone` is sampled with either a pass or `wrCmpEn`=0 (in which case `cmpFail` has no effect), and the vector repeat count is not zero, the count drops by one. One gap cycle later the loads base+1, base+2, base+3 follow.
- R7: When the count selected by R5 or R6 is already zero, the loop exits without wrapping around, and `busy` is low in the next cycle. A job on a passing path therefore runs `wrVecRepeat`+1 vectors per sequence pass.
- R8: A `newData` pulse while `busy` is high is ignored: every following pointer address uses the stored base. A `vecDone` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| newData | input | 1 | One-cycle processor start write |
| wrSeqMode | input | 1 | 1 = sequence mode, 0 = single vector |
| wrCmpEn | input | 1 | Compare (or masked compare) enabled |
| wrSeqRepeat | input | CNT_W | Sequence restarts allowed on fail |
| wrVecRepeat | input | CNT_W | Vector repeats on pass |
| wrBaseAddr | input | ADDR_W | Header block base address |
| vecDone | input | 1 | Current vector fully shifted and compared |
| cmpFail | input | 1 | Compare result, valid with vecDone |
| busy | output | 1 | Job in progress |
| ptrLoad | output | 1 | Pointer register loaded this cycle |
| ptrAddr | output | ADDR_W | Pointer register value |
| shiftStart | output | 1 | Start strobe to serializer |

## Verification
Each job is checked cycle by cycle against a reference loop in the bench that tracks both repeat counts. Directed jobs cover a fail with no sequence repeats left, a pass with no vector repeats left, fails while compare is disabled, and a base address that wraps. Together they tell apart the exit paths, the choice between restart and re-run, and offset arithmetic that wraps incorrectly. Random jobs mix the two modes, compare on and off, and pass/fail patterns, with start writes injected while busy. These show that sequence restarts reload the vector count and that writes made while busy leave the stored base untouched.

// File: rtl/scan_dispatch_pkg.sv
package scan_dispatch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_LDSEQ,
    ST_LDVEC,
    ST_LDMAC,
    ST_LDDATA,
    ST_RUN
  } ctlState_t;

  // Offsets from the header base; the fetch order depends on them.
  typedef enum logic [1:0] {
    HDR_SEQ   = 2'd0,
    HDR_VEC   = 2'd1,
    HDR_MAC   = 2'd2,
    AREA_DATA = 2'd3
  } ptrSel_t;

  typedef struct packed {
    logic    capture;
    logic    ptrLd;
    ptrSel_t ptrSel;
    logic    fireStart;
    logic    seqDec;
    logic    vecDec;
    logic    vecReload;
  } dpStrobe_t;

endpackage

// File: rtl/scan_dispatch_ctl.sv
module scan_dispatch_ctl
  import scan_dispatch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      newData,
  input  logic      vecDone,
  input  logic      cmpFail,
  input  logic      seqMode,
  input  logic      cmpEn,
  input  logic      seqZero,
  input  logic      vecZero,
  output dpStrobe_t stb,
  output logic      busy
);

  ctlState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    stb.ptrSel = HDR_SEQ;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (newData) begin
          stb.capture = 1'b1;
          nextState   = ST_DECODE;
        end
      end
      ST_DECODE: begin
        stb.ptrLd  = 1'b1;
        stb.ptrSel = seqMode ? HDR_SEQ : HDR_VEC;
        nextState  = seqMode ? ST_LDVEC : ST_LDMAC;
      end
      ST_LDSEQ: begin
        stb.ptrLd  = 1'b1;
        stb.ptrSel = HDR_SEQ;
        nextState  = ST_LDVEC;
      end
      ST_LDVEC: begin
        stb.ptrLd  = 1'b1;
        stb.ptrSel = HDR_VEC;
        nextState  = ST_LDMAC;
      end
      ST_LDMAC: begin
        stb.ptrLd  = 1'b1;
        stb.ptrSel = HDR_MAC;
        nextState  = ST_LDDATA;
      end
      ST_LDDATA: begin
        stb.ptrLd     = 1'b1;
        stb.ptrSel    = AREA_DATA;
        stb.fireStart = 1'b1;
        nextState     = ST_RUN;
      end
      ST_RUN: begin
        if (vecDone) begin
          if (cmpEn && cmpFail) begin
            if (!seqZero) begin
              stb.seqDec    = 1'b1;
              stb.vecReload = 1'b1;
              nextState     = seqMode ? ST_LDSEQ : ST_LDVEC;
            end else begin
              nextState = ST_IDLE;
            end
          end else if (!vecZero) begin
            stb.vecDec = 1'b1;
            nextState  = ST_LDVEC;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R1
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && newData) |=> busy);

  // R8
  ignore_busy_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && newData) |-> !stb.capture);

endmodule

// File: rtl/scan_dispatch_dp.sv
module scan_dispatch_dp
  import scan_dispatch_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              wrSeqMode,
  input  logic              wrCmpEn,
  input  logic [CNT_W-1:0]  wrSeqRepeat,
  input  logic [CNT_W-1:0]  wrVecRepeat,
  input  logic [ADDR_W-1:0] wrBaseAddr,
  output logic              seqMode,
  output logic              cmpEn,
  output logic              seqZero,
  output logic              vecZero,
  output logic              ptrLoad,
  output logic [ADDR_W-1:0] ptrAddr,
  output logic              shiftStart
);

  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(AREA_DATA);
  localparam logic [ADDR_W-1:0] VEC_OFS  = ADDR_W'(HDR_VEC);

  logic [ADDR_W-1:0] cfgBase;
  logic [CNT_W-1:0]  cfgVecRep;
  logic [CNT_W-1:0]  seqLeft;
  logic [CNT_W-1:0]  vecLeft;

  // Start/setup registers, written only on an accepted start.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqMode   <= 1'b0;
      cmpEn     <= 1'b0;
      cfgBase   <= '0;
      cfgVecRep <= '0;
    end else if (stb.capture) begin
      seqMode   <= wrSeqMode;
      cmpEn     <= wrCmpEn;
      cfgBase   <= wrBaseAddr;
      cfgVecRep <= wrVecRepeat;
    end
  end

  // Repeat counters.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqLeft <= '0;
      vecLeft <= '0;
    end else begin
      if (stb.capture)     seqLeft <= wrSeqRepeat;
      else if (stb.seqDec) seqLeft <= seqLeft - 1'b1;

      if (stb.capture)        vecLeft <= wrVecRepeat;
      else if (stb.vecReload) vecLeft <= cfgVecRep;
      else if (stb.vecDec)    vecLeft <= vecLeft - 1'b1;
    end
  end

  assign seqZero = (seqLeft == '0);
  assign vecZero = (vecLeft == '0);

  // Pointer register and serializer strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrAddr    <= '0;
      ptrLoad    <= 1'b0;
      shiftStart <= 1'b0;
    end else begin
      ptrLoad    <= stb.ptrLd;
      shiftStart <= stb.fireStart;
      if (stb.ptrLd) ptrAddr <= cfgBase + ADDR_W'(stb.ptrSel);
    end
  end

  // R3
  header_chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ptrLoad && !shiftStart && ptrAddr != cfgBase + DATA_OFS)
      |=> (ptrLoad && ptrAddr == $past(ptrAddr) + 1'b1));

  // R4
  start_with_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftStart |-> (ptrLoad && ptrAddr == cfgBase + DATA_OFS));

  // R6
  vector_rerun_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.vecDec |=> ##1 (ptrLoad && ptrAddr == cfgBase + VEC_OFS));

  // R7
  vec_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.vecDec |-> (vecLeft != '0));

  // R7
  seq_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.seqDec |-> (seqLeft != '0));

  // R5
  reload_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.vecReload |=> (vecLeft == cfgVecRep && seqLeft == $past(seqLeft) - 1'b1));

endmodule

// File: rtl/scan_dispatch.sv
module scan_dispatch
  import scan_dispatch_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              newData,
  input  logic              wrSeqMode,
  input  logic              wrCmpEn,
  input  logic [CNT_W-1:0]  wrSeqRepeat,
  input  logic [CNT_W-1:0]  wrVecRepeat,
  input  logic [ADDR_W-1:0] wrBaseAddr,
  input  logic              vecDone,
  input  logic              cmpFail,
  output logic              busy,
  output logic              ptrLoad,
  output logic [ADDR_W-1:0] ptrAddr,
  output logic              shiftStart
);

  dpStrobe_t stb;
  logic seqMode, cmpEn, seqZero, vecZero;

  scan_dispatch_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .newData (newData),
    .vecDone (vecDone),
    .cmpFail (cmpFail),
    .seqMode (seqMode),
    .cmpEn   (cmpEn),
    .seqZero (seqZero),
    .vecZero (vecZero),
    .stb     (stb),
    .busy    (busy)
  );

  scan_dispatch_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrSeqMode   (wrSeqMode),
    .wrCmpEn     (wrCmpEn),
    .wrSeqRepeat (wrSeqRepeat),
    .wrVecRepeat (wrVecRepeat),
    .wrBaseAddr  (wrBaseAddr),
    .seqMode     (seqMode),
    .cmpEn       (cmpEn),
    .seqZero     (seqZero),
    .vecZero     (vecZero),
    .ptrLoad     (ptrLoad),
    .ptrAddr     (ptrAddr),
    .shiftStart  (shiftStart)
  );

endmodule

// File: tb/scan_dispatch_test.sv
module scan_dispatch_test;

  localparam int ADDR_W = 8;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic newData = 1'b0;
  logic wrSeqMode = 1'b0;
  logic wrCmpEn = 1'b0;
  logic [CNT_W-1:0] wrSeqRepeat = '0;
  logic [CNT_W-1:0] wrVecRepeat = '0;
  logic [ADDR_W-1:0] wrBaseAddr = '0;
  logic vecDone = 1'b0;
  logic cmpFail = 1'b0;
  logic busy, ptrLoad, shiftStart;
  logic [ADDR_W-1:0] ptrAddr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  scan_dispatch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .newData(newData), .wrSeqMode(wrSeqMode),
    .wrCmpEn(wrCmpEn), .wrSeqRepeat(wrSeqRepeat), .wrVecRepeat(wrVecRepeat),
    .wrBaseAddr(wrBaseAddr), .vecDone(vecDone), .cmpFail(cmpFail),
    .busy(busy), .ptrLoad(ptrLoad), .ptrAddr(ptrAddr), .shiftStart(shiftStart)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] hdrAddr(input logic [ADDR_W-1:0] base, input int ofs);
    return base + ADDR_W'(ofs);
  endfunction

  // Expects consecutive loads from offset (withSeq ? 0 : 1) through 3.
  task automatic expectBurst(input logic [ADDR_W-1:0] base, input bit withSeq, input string req);
    for (int k = (withSeq ? 0 : 1); k < 4; k++) begin
      @(negedge clk);
      newData = 1'b0;
      chk(ptrLoad == 1'b1, req, "ptrLoad", int'(ptrLoad), 1);
      chk(ptrAddr == hdrAddr(base, k), req, "ptrAddr", int'(ptrAddr), int'(hdrAddr(base, k)));
      chk(shiftStart == (k == 3), "R4", "shiftStart", int'(shiftStart), int'(k == 3));
    end
  endtask

  // failMode: 0 all pass, 1 all fail, 2 random
  task automatic runJob(input bit sm, input bit ce, input int sr, input int vr,
                        input logic [ADDR_W-1:0] base, input int failMode, input bit poke);
    int seqLeft = sr;
    int vecLeft = vr;
    bit fail, effFail, leave;
    @(negedge clk);
    wrSeqMode = sm; wrCmpEn = ce; wrSeqRepeat = CNT_W'(sr);
    wrVecRepeat = CNT_W'(vr); wrBaseAddr = base; newData = 1'b1;
    @(negedge clk);
    newData = 1'b0;
    wrBaseAddr = base ^ 8'h5A; wrSeqMode = ~sm; wrSeqRepeat = '1; wrVecRepeat = '1;
    chk(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
    chk(ptrLoad == 1'b0, "R1", "no load in decode cycle", int'(ptrLoad), 0);
    if (poke) newData = 1'b1;
    expectBurst(base, sm, "R2");
    leave = 1'b0;
    while (!leave) begin
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk);
        chk(busy && !ptrLoad && !shiftStart, "R6", "idle wait in run",
            int'({busy, ptrLoad, shiftStart}), 4);
      end
      fail = (failMode == 1) || (failMode == 2 && $urandom_range(0, 1) == 1);
      vecDone = 1'b1; cmpFail = fail;
      @(negedge clk);
      vecDone = 1'b0; cmpFail = 1'b0;
      effFail = ce && fail;
      if (effFail) begin
        if (seqLeft > 0) begin
          seqLeft--; vecLeft = vr;
          chk(busy && !ptrLoad, "R5", "gap before restart", int'({busy, ptrLoad}), 2);
          if (poke) newData = 1'b1;
          expectBurst(base, sm, "R5");
        end else begin
          chk(busy == 1'b0, "R7", "exit on fail at zero", int'(busy), 0);
          leave = 1'b1;
        end
      end else begin
        if (vecLeft > 0) begin
          vecLeft--;
          chk(busy && !ptrLoad, "R6", "gap before rerun", int'({busy, ptrLoad}), 2);
          if (poke) newData = 1'b1;
          expectBurst(base, 1'b0, "R6");
        end else begin
          chk(busy == 1'b0, "R7", "exit on pass at zero", int'(busy), 0);
          leave = 1'b1;
        end
      end
    end
    // R8: vecDone while idle has no effect
    vecDone = 1'b1; cmpFail = 1'b1;
    @(negedge clk);
    vecDone = 1'b0; cmpFail = 1'b0;
    @(negedge clk);
    chk(!busy && !ptrLoad && !shiftStart, "R8", "idle vecDone ignored",
        int'({busy, ptrLoad, shiftStart}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog act=%0d exp=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!busy && !ptrLoad && !shiftStart, "R1", "reset state",
        int'({busy, ptrLoad, shiftStart}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !ptrLoad && !shiftStart, "R1", "after reset release",
        int'({busy, ptrLoad, shiftStart}), 0);

    // directed corners
    runJob(1'b1, 1'b1, 0, 0, 8'h10, 1, 1'b0);  // R7 fail, no sequence repeats
    runJob(1'b0, 1'b1, 0, 2, 8'h20, 0, 1'b0);  // R6 single mode passes, then R7
    runJob(1'b1, 1'b0, 0, 1, 8'h30, 1, 1'b1);  // R6 fail ignored with compare off, R8 pokes
    runJob(1'b1, 1'b1, 2, 1, 8'hFE, 1, 1'b0);  // R5 restarts, address wrap R3
    runJob(1'b0, 1'b1, 1, 0, 8'hFD, 1, 1'b1);  // R5 single mode restart

    for (int j = 0; j < 40; j++) begin
      runJob(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             $urandom_range(0, 3), $urandom_range(0, 3),
             ADDR_W'($urandom_range(0, 255)), 2, 1'($urandom_range(0, 1)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule